// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block takes a 16-bit segmented core into a real-mode interrupt. A request pulse with an 8-bit vector number is latched as pending. The block then checks whether the interrupt may be entered now. Once it is accepted, the block saves the machine state on the stack through a byte-wide memory port. It then fetches the handler address from the vector table at the bottom of physical memory. At the end it returns the updated FLAGS, CS, IP and SP to the core with a one-cycle done strobe.

The core supplies its live register values and two prefix status lines. The block snapshots these values when it accepts a request. The first line is raised while a segment-override prefix still governs the current instruction. The second is raised when a prefix byte (repeat or segment override) sits just before the interrupted point. A request that arrives while an entry is running is kept and served afterwards.

Top module: `intr_entry_seq`

## Requirements
- R1: A pending request is accepted only when FLAGS bit 9 (interrupt enable) is 1 or the pending vector is 0 or 2. Any other request stays pending and is accepted once bit 9 becomes 1.
- R2: No request is accepted while `seg_ovr` is 1. A held request is accepted after `seg_ovr` returns to 0.
- R3: An entry makes exactly six byte writes, each word low byte first. FLAGS goes at offset SP-2, CS at SP-4 and IP at SP-6, in that order. Offsets wrap at 16 bits, and each physical address is (SS*16 + offset) modulo 2^20.
- R4: The saved IP is `ip_in` minus 1 when `prefix_pend` is 1 at acceptance, and `ip_in` otherwise.
- R5: After the writes, four byte reads take place at physical addresses vector*4 through vector*4+3. `new_ip` is formed from the bytes at +0 (low) and +1. `new_cs` is formed from the bytes at +2 (low) and +3.
- R6: While `done` is 1, `new_sp` equals the accepted SP minus 6 (mod 2^16). `new_flags` equals the accepted FLAGS with bits 9 and 8 cleared.
- R7: One byte transfer completes per cycle with `mem_req` and `mem_rdy` both 1. While `mem_rdy` is 0, address, direction and write data hold steady.
- R8: `busy` is 1 from acceptance through the `done` cycle. `done` lasts one cycle, and `clr_ovr` is 1 in that same cycle.
- R9: A request that arrives while `busy` is 1 is not lost. It is entered after the current entry finishes.
- R10: After reset, `busy`, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | One-cycle interrupt request pulse |
| irq_vec | input | 8 | Vector number with the request |
| flags_in | input | 16 | Current FLAGS |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| seg_ovr | input | 1 | Segment-override prefix in effect |
| prefix_pend | input | 1 | A prefix byte precedes the interrupted point |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_rdy | input | 1 | Transfer completes this cycle |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Entry complete, write-back valid |
| clr_ovr | output | 1 | Clear segment-override state |
| new_flags | output | 16 | FLAGS to write back |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 16 | Handler instruction pointer |
| new_sp | output | 16 | Stack pointer after the pushes |

## Verification
The hardest situation to create is a second request that lands in the middle of an entry. It must then be served from the pending latch rather than dropped. The stimulus raises a request, waits until `busy` is seen and the stall-driven transfers have started, then pulses a second vector. It checks both entries in turn. Stack wrap cases are covered by the vector sweep, which includes SP near zero and SS near the top of memory. Held requests are covered by keeping the enable bit or the override line in the blocking state for several cycles before releasing it.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int PHYS_W     = 20;
    localparam int VEC_W      = 8;
    localparam int IE_POS     = 9;   // interrupt enable flag position
    localparam int TRAP_POS   = 8;   // single-step flag position
    localparam int PUSH_WORDS = 3;
    localparam int VEC_BYTES  = 4;
    localparam int N_STEPS    = 2 * PUSH_WORDS + VEC_BYTES;
    localparam int STEP_W     = $clog2(N_STEPS);
    localparam int N_WRITES   = 2 * PUSH_WORDS;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] ss;
        logic [WORD_W-1:0] sp;
        logic [VEC_W-1:0]  vec;
    } entry_ctx_t;

    function automatic logic [PHYS_W-1:0] seg_to_phys(
        input logic [WORD_W-1:0] seg, input logic [WORD_W-1:0] off);
        return {seg, 4'b0000} + {{(PHYS_W-WORD_W){1'b0}}, off};
    endfunction

    function automatic logic vec_unmaskable(input logic [VEC_W-1:0] v);
        return (v == VEC_W'(0)) || (v == VEC_W'(2));
    endfunction
endpackage

// File: rtl/intr_gate.sv
module intr_gate
    import intr_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             ie_flag,
    input  logic             seg_ovr,
    input  logic             idle,
    output logic             accept,
    output logic [VEC_W-1:0] pend_vec
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_vec <= '0;
        end else if (irq_req) begin
            pend     <= 1'b1;
            pend_vec <= irq_vec;
        end else if (accept) begin
            pend     <= 1'b0;
        end
    end

    assign accept = idle && pend && !seg_ovr &&
                    (ie_flag || vec_unmaskable(pend_vec));
endmodule

// File: rtl/intr_xfer_gen.sv
module intr_xfer_gen
    import intr_entry_pkg::*;
(
    input  entry_ctx_t        ctx,
    input  logic [STEP_W-1:0] step,
    output logic [PHYS_W-1:0] addr,
    output logic              we,
    output logic [BYTE_W-1:0] wdata
);
    logic [WORD_W-1:0] push_word [PUSH_WORDS];
    logic [1:0]        widx;
    logic [WORD_W-1:0] depth;
    logic [WORD_W-1:0] off;
    logic [STEP_W-1:0] ridx;
    logic [WORD_W-1:0] cur;

    assign push_word[0] = ctx.flags;
    assign push_word[1] = ctx.cs;
    assign push_word[2] = ctx.ip;

    always_comb begin
        widx  = step[2:1];
        depth = WORD_W'({widx, 1'b0}) + WORD_W'(2);
        off   = ctx.sp - depth + WORD_W'(step[0]);
        ridx  = step - STEP_W'(N_WRITES);
        cur   = (widx < 2'(PUSH_WORDS)) ? push_word[widx] : '0;
        if (step < STEP_W'(N_WRITES)) begin
            we    = 1'b1;
            addr  = seg_to_phys(ctx.ss, off);
            wdata = step[0] ? cur[WORD_W-1:BYTE_W] : cur[BYTE_W-1:0];
        end else begin
            we    = 1'b0;
            addr  = PHYS_W'({ctx.vec, 2'b00}) + PHYS_W'(ridx);
            wdata = '0;
        end
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [WORD_W-1:0] ss_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic              seg_ovr,
    input  logic              prefix_pend,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PHYS_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              done,
    output logic              clr_ovr,
    output logic [WORD_W-1:0] new_flags,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_sp
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);
    localparam logic [WORD_W-1:0] FLAG_CLR  =
        ~((WORD_W'(1) << IE_POS) | (WORD_W'(1) << TRAP_POS));
    localparam logic [WORD_W-1:0] FRAME_SZ  = WORD_W'(2 * PUSH_WORDS);

    seq_state_t                          state;
    logic [STEP_W-1:0]                   step;
    entry_ctx_t                          ctx;
    logic [VEC_BYTES-1:0][BYTE_W-1:0]    vbytes;
    logic                                accept;
    logic [VEC_W-1:0]                    pend_vec;
    logic [STEP_W-1:0]                   ridx;

    intr_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .ie_flag  (flags_in[IE_POS]),
        .seg_ovr  (seg_ovr),
        .idle     (state == SQ_IDLE),
        .accept   (accept),
        .pend_vec (pend_vec)
    );

    intr_xfer_gen u_gen (
        .ctx   (ctx),
        .step  (step),
        .addr  (mem_addr),
        .we    (mem_we),
        .wdata (mem_wdata)
    );

    assign ridx = step - STEP_W'(N_WRITES);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            step   <= '0;
            ctx    <= '0;
            vbytes <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        ctx.flags <= flags_in;
                        ctx.cs    <= cs_in;
                        ctx.ip    <= ip_in - WORD_W'(prefix_pend);
                        ctx.ss    <= ss_in;
                        ctx.sp    <= sp_in;
                        ctx.vec   <= pend_vec;
                        step      <= '0;
                        state     <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (mem_rdy) begin
                        if (!mem_we)
                            vbytes[ridx[1:0]] <= mem_rdata;
                        if (step == LAST_STEP)
                            state <= SQ_DONE;
                        else
                            step <= step + STEP_W'(1);
                    end
                end
                SQ_DONE: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == SQ_XFER);
    assign busy      = (state != SQ_IDLE);
    assign done      = (state == SQ_DONE);
    assign clr_ovr   = done;
    assign new_flags = ctx.flags & FLAG_CLR;
    assign new_sp    = ctx.sp - FRAME_SZ;
    assign new_ip    = {vbytes[1], vbytes[0]};
    assign new_cs    = {vbytes[3], vbytes[2]};
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        seg_ovr,
    input logic        mem_req,
    input logic        mem_we,
    input logic [19:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_rdy,
    input logic        busy,
    input logic        done,
    input logic        clr_ovr,
    input logic [15:0] new_flags
);
    p_defer_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && seg_ovr) |=> !busy);

    p_vec_low_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr[19:10] == 10'd0));

    p_flags_clear_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (new_flags[9:8] == 2'b00));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_req_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req || done) |-> busy);

    p_clr_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        clr_ovr |-> (done && !mem_req));
endmodule

bind intr_entry_seq intr_entry_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .seg_ovr   (seg_ovr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdy   (mem_rdy),
    .busy      (busy),
    .done      (done),
    .clr_ovr   (clr_ovr),
    .new_flags (new_flags)
);

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
    logic        seg_ovr = 1'b0, prefix_pend = 1'b0;
    logic        mem_req, mem_we, mem_rdy = 1'b0;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, clr_ovr;
    logic [15:0] new_flags, new_cs, new_ip, new_sp;

    int tests = 0, fails = 0;
    int stall = 0, stall_cnt = 0;
    int wn = 0;
    logic [19:0] wlog_a [6];
    logic [7:0]  wlog_d [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_entry_seq i_intr_entry_seq (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in),
        .sp_in(sp_in), .seg_ovr(seg_ovr), .prefix_pend(prefix_pend),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .busy(busy), .done(done), .clr_ovr(clr_ovr), .new_flags(new_flags),
        .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp)
    );

    function automatic logic [7:0] mem_val(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_val(mem_addr);

    // memory responder with stall pattern; logs writes that complete
    always @(negedge clk) begin
        if (mem_req) begin
            if (stall_cnt >= stall) begin
                mem_rdy <= 1'b1;
                stall_cnt = 0;
                if (mem_we && wn < 6) begin
                    wlog_a[wn] = mem_addr;
                    wlog_d[wn] = mem_wdata;
                end
                if (mem_we) wn = wn + 1;
            end else begin
                mem_rdy <= 1'b0;
                stall_cnt = stall_cnt + 1;
            end
        end else begin
            mem_rdy <= 1'b0;
            stall_cnt = 0;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [7:0] v);
        @(negedge clk);
        irq_vec = v;
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic hold_check(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        check(req, seen, 0);
    endtask

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return 20'(({4'b0, s} << 4) + {4'b0, o});
    endfunction

    // waits for done and checks the full entry against the driven register values
    task automatic expect_entry(input logic [7:0] v);
        logic [15:0] sip, word, ofs;
        logic [19:0] va;
        int t = 0;
        sip = ip_in - 16'(prefix_pend);
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check("R8 done reached", done, 1);
        check("R8 busy during done", busy, 1);
        check("R8 clr_ovr with done", clr_ovr, 1);
        check("R3 write count", wn, 6);
        for (int k = 0; k < 3; k++) begin
            word = (k == 0) ? flags_in : (k == 1) ? cs_in : sip;
            for (int b = 0; b < 2; b++) begin
                ofs = sp_in - 16'(2 * (k + 1)) + 16'(b);
                check("R3 push address", wlog_a[2*k+b], phys(ss_in, ofs));
                if (k == 2)
                    check("R4 saved ip byte", wlog_d[2*k+b], b ? word[15:8] : word[7:0]);
                else
                    check("R3 push data", wlog_d[2*k+b], b ? word[15:8] : word[7:0]);
            end
        end
        va = {10'd0, v, 2'b00};
        check("R5 new_ip", new_ip, {mem_val(va + 20'd1), mem_val(va)});
        check("R5 new_cs", new_cs, {mem_val(va + 20'd3), mem_val(va + 20'd2)});
        check("R6 new_sp", new_sp, 16'(sp_in - 16'd6));
        check("R6 new_flags", new_flags, flags_in & 16'hFCFF);
        @(negedge clk);
        check("R8 done one cycle", done, 0);
        wn = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 busy after reset", busy, 0);
        check("R10 done after reset", done, 0);
        check("R10 mem_req after reset", mem_req, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1/R3/R4/R5/R6/R7 sweep over every vector with varied stalls and stacks
        for (int v = 0; v < 256; v++) begin
            flags_in    = 16'({v[7:0], 8'h00}) ^ 16'h0F35 | 16'h0200;
            cs_in       = 16'(v * 257);
            ip_in       = 16'(v * 31 + 7);
            ss_in       = 16'(16'hFFF0 + v);
            sp_in       = 16'(v * 6);
            prefix_pend = v[0];
            stall       = v % 3;
            pulse_req(8'(v));
            expect_entry(8'(v));
        end
        stall = 1;

        // R1: with enable clear, vectors 0 and 2 still enter; others are held
        flags_in = 16'h01C4; cs_in = 16'h1234; ip_in = 16'h0100;
        ss_in = 16'h2000; sp_in = 16'h0010; prefix_pend = 1'b0;
        pulse_req(8'd0);
        expect_entry(8'd0);
        pulse_req(8'd2);
        expect_entry(8'd2);
        for (int j = 0; j < 3; j++) begin
            logic [7:0] hv;
            hv = (j == 0) ? 8'd1 : (j == 1) ? 8'd3 : 8'd255;
            flags_in = 16'h01C4;
            pulse_req(hv);
            hold_check("R1 masked request held", 12);
            flags_in = 16'h03C4;
            expect_entry(hv);
        end

        // R2: override in effect defers entry, even for an unmaskable vector
        seg_ovr = 1'b1;
        pulse_req(8'd2);
        hold_check("R2 deferred by override", 12);
        seg_ovr = 1'b0;
        expect_entry(8'd2);

        // R4: prefix pending with IP at zero wraps the saved value
        ip_in = 16'h0000; prefix_pend = 1'b1;
        pulse_req(8'd7);
        expect_entry(8'd7);
        prefix_pend = 1'b0; ip_in = 16'h0200;

        // R9: second request during a running entry is kept
        stall = 2;
        pulse_req(8'd10);
        while (!busy) @(negedge clk);
        repeat (3) @(negedge clk);
        pulse_req(8'd11);
        expect_entry(8'd10);
        expect_entry(8'd11);
        check("R9 idle after both", busy, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule